// File: doc/BRIEF.md
# Capture/Compare Timer with Pin Ownership

This block is a general-purpose timer with eight channels. A 16-bit free-running counter advances on ticks from a prescaler that divides the clock by a power of two from 1 to 128. Each channel owns a 16-bit value register. A per-channel mode bit sets how the channel works. In capture mode the channel latches the counter when its synchronized pin input rises. In compare mode the channel raises an event when the counter reaches its value, and it can toggle a pin-drive state.

Every channel also has the logic for its port pin. By default a pin acts as general-purpose I/O: a direction register sets the output enable and a port data latch sets the driven level. When a channel is in compare mode and its output action is enabled, the timer takes the pin. The pin is then forced to output and carries the compare state. Port writes made while the timer owns the pin are kept in the latch. The latched level appears on the pin once the timer releases it.

Software reaches all state through a register bus with a 4-bit address, a write strobe and a read port that is decoded combinationally. The per-channel event flags are also brought out as a port.

Top module: `cct_timer`

## Requirements
- R1: During and after reset, the mode register, event flags, counter, direction register and port latch are all zero, so no pin is driven (pin_oe = 0).
- R2: The control register (address 0x0) holds the enable in bit 0 and the divide select `s` in bits 3:1. While the block is enabled, the counter advances by one every 2^s clocks. While it is disabled, the counter holds its value.
- R3: The mode register (address 0x1) reads back the value last written, at any time. Bit i = 1 puts channel i in compare mode and bit i = 0 puts it in capture mode.
- R4: When a channel is in compare mode and its bit in the output-action register (address 0x2) is set, the timer owns the pin. pin_oe is then 1 whatever the direction register (address 0x6) holds, and pin_out is the channel's compare state.
- R5: When the timer does not own a pin, pin_oe equals the channel's direction bit and pin_out equals its port latch bit (address 0x5).
- R6: A write to the port latch while the timer owns the pin does not change pin_out. The written level is driven once the output action is cleared.
- R7: A capture-mode channel synchronizes its pin through two flops. On a rising edge it stores the counter value and sets its flag, three clocks after the pin rises. A channel in compare mode ignores pin edges.
- R8: A compare-mode channel sets its flag when the counter, on a tick, steps to the channel's value. If its output action is enabled, the compare state toggles at the same edge. The compare state is zero after reset.
- R9: Writing 1 to a bit of the flag register (address 0x3) clears that flag. If an event and a clear for the same flag land in the same cycle, the flag ends up set.
- R10: A write to the counter address (0x4) has no effect. A read at 0x4 returns the current count. A read at 0x8+i returns channel i's value register, which software may write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 4 | Register address |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data for bus_addr (combinational) |
| pin_in | input | 8 | Sampled pin levels, one per channel |
| pin_out | output | 8 | Pin drive levels |
| pin_oe | output | 8 | Pin output enables |
| evt_flags | output | 8 | Per-channel event flags |

## Verification
The bench goes after the cases that break pin ownership.

- It writes the direction register while the timer owns a pin. A design that still obeys the direction bit would float the compare output.
- It writes the port latch during ownership and then releases the pin. A design that drops the write, or passes it straight through, shows the wrong level either before or after the release.
- It keeps clears hammering the flag register across a compare match, so that a clear and an event land in the same cycle. A design that gives the clear priority would lose the event.
- It raises a pin on a channel in compare mode to expose a false capture.
- It writes the counter address to catch a counter that accepts the write.
- It measures the counter over a whole divided window to catch an off-by-one in the prescaler mask.

// File: rtl/cct_pkg.sv
package cct_pkg;

    // Register addresses whose position other logic decodes
    typedef enum logic [3:0] {
        A_CTRL  = 4'h0,
        A_MODE  = 4'h1,
        A_ACT   = 4'h2,
        A_FLAG  = 4'h3,
        A_COUNT = 4'h4,
        A_PORT  = 4'h5,
        A_DIR   = 4'h6
    } reg_addr_e;

    // Address bit that selects the channel value window (0x8..0xF)
    localparam int CH_WIN_BIT = 3;

endpackage

// File: rtl/cct_prescaler.sv
module cct_prescaler #(
    parameter int PSW = 3
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           en,
    input  logic [PSW-1:0] sel,
    output logic           tick
);
    localparam int DIVW = (1 << PSW) - 1;

    logic [DIVW-1:0] pre_d, pre_q;
    logic [DIVW-1:0] mask;

    always_comb begin
        mask  = ~({DIVW{1'b1}} << sel);
        tick  = en && ((pre_q & mask) == mask);
        pre_d = en ? pre_q + DIVW'(1) : '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pre_q <= '0;
        else        pre_q <= pre_d;
    end
endmodule

// File: rtl/cct_channel.sv
module cct_channel #(
    parameter int CW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          pin_in,
    input  logic          is_cmp,
    input  logic          act,
    input  logic          tick,
    input  logic [CW-1:0] count_q,
    input  logic [CW-1:0] count_nx,
    input  logic          wr,
    input  logic [CW-1:0] wdata,
    output logic [CW-1:0] value,
    output logic          evt,
    output logic          cmp_out
);
    typedef struct packed {
        logic          s1;
        logic          s2;
        logic          prev;
        logic          cout;
        logic [CW-1:0] value;
    } ch_t;

    ch_t  c_d, c_q;
    logic rise, cap, hit;

    always_comb begin
        c_d     = c_q;
        c_d.s1  = pin_in;
        c_d.s2  = c_q.s1;
        c_d.prev = c_q.s2;
        rise    = c_q.s2 & ~c_q.prev;
        cap     = ~is_cmp & rise;
        hit     = is_cmp & tick & (count_nx == c_q.value);
        if (cap)     c_d.value = count_q;
        else if (wr) c_d.value = wdata;
        if (hit && act) c_d.cout = ~c_q.cout;
        evt     = cap | hit;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) c_q <= '0;
        else        c_q <= c_d;
    end

    assign value   = c_q.value;
    assign cmp_out = c_q.cout;
endmodule

// File: rtl/cct_timer.sv
module cct_timer #(
    parameter int NCH = 8,
    parameter int CW  = 16,
    parameter int PSW = 3
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           bus_wr,
    input  logic [3:0]     bus_addr,
    input  logic [CW-1:0]  bus_wdata,
    output logic [CW-1:0]  bus_rdata,
    input  logic [NCH-1:0] pin_in,
    output logic [NCH-1:0] pin_out,
    output logic [NCH-1:0] pin_oe,
    output logic [NCH-1:0] evt_flags
);
    import cct_pkg::*;

    localparam int CSW = $clog2(NCH);

    typedef struct packed {
        logic           en;
        logic [PSW-1:0] sel;
        logic [NCH-1:0] mode;
        logic [NCH-1:0] act;
        logic [NCH-1:0] flags;
        logic [NCH-1:0] port;
        logic [NCH-1:0] dir;
        logic [CW-1:0]  count;
    } st_t;

    st_t            s_d, s_q;
    logic           tick;
    logic [CW-1:0]  count_nx;
    logic [NCH-1:0] ch_evt, ch_cout, own, clr;
    logic [CW-1:0]  ch_val [NCH];

    cct_prescaler #(.PSW(PSW)) u_pre (
        .clk  (clk),
        .rst_n(rst_n),
        .en   (s_q.en),
        .sel  (s_q.sel),
        .tick (tick)
    );

    assign count_nx = s_q.count + CW'(tick);

    for (genvar i = 0; i < NCH; i++) begin : g_ch
        cct_channel #(.CW(CW)) u_ch (
            .clk     (clk),
            .rst_n   (rst_n),
            .pin_in  (pin_in[i]),
            .is_cmp  (s_q.mode[i]),
            .act     (s_q.act[i]),
            .tick    (tick),
            .count_q (s_q.count),
            .count_nx(count_nx),
            .wr      (bus_wr && bus_addr[CH_WIN_BIT] &&
                      (bus_addr[CSW-1:0] == CSW'(i))),
            .wdata   (bus_wdata),
            .value   (ch_val[i]),
            .evt     (ch_evt[i]),
            .cmp_out (ch_cout[i])
        );
    end

    always_comb begin
        s_d       = s_q;
        s_d.count = count_nx;
        clr       = '0;
        if (bus_wr) begin
            case (bus_addr)
                A_CTRL: begin
                    s_d.en  = bus_wdata[0];
                    s_d.sel = bus_wdata[PSW:1];
                end
                A_MODE:  s_d.mode = bus_wdata[NCH-1:0];
                A_ACT:   s_d.act  = bus_wdata[NCH-1:0];
                A_FLAG:  clr      = bus_wdata[NCH-1:0];
                A_PORT:  s_d.port = bus_wdata[NCH-1:0];
                A_DIR:   s_d.dir  = bus_wdata[NCH-1:0];
                default: ;
            endcase
        end
        s_d.flags = (s_q.flags & ~clr) | ch_evt;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    // Pin ownership: timer drives when compare mode and output action are set
    always_comb begin
        own     = s_q.mode & s_q.act;
        pin_oe  = own | s_q.dir;
        pin_out = (own & ch_cout) | (~own & s_q.port);
    end

    always_comb begin
        bus_rdata = '0;
        case (bus_addr)
            A_CTRL:  bus_rdata = CW'({s_q.sel, s_q.en});
            A_MODE:  bus_rdata = CW'(s_q.mode);
            A_ACT:   bus_rdata = CW'(s_q.act);
            A_FLAG:  bus_rdata = CW'(s_q.flags);
            A_COUNT: bus_rdata = s_q.count;
            A_PORT:  bus_rdata = CW'(s_q.port);
            A_DIR:   bus_rdata = CW'(s_q.dir);
            default: if (bus_addr[CH_WIN_BIT]) bus_rdata = ch_val[bus_addr[CSW-1:0]];
        endcase
    end

    assign evt_flags = s_q.flags;
endmodule

// File: rtl/cct_timer_chk.sv
module cct_timer_chk #(
    parameter int NCH = 8,
    parameter int CW  = 16
) (
    input logic           clk,
    input logic           rst_n,
    input logic           en,
    input logic [CW-1:0]  count,
    input logic [NCH-1:0] mode,
    input logic [NCH-1:0] act,
    input logic [NCH-1:0] dir,
    input logic [NCH-1:0] port,
    input logic [NCH-1:0] pin_oe,
    input logic [NCH-1:0] pin_out,
    input logic [NCH-1:0] flags,
    input logic           bus_wr,
    input logic [3:0]     bus_addr,
    input logic [CW-1:0]  bus_wdata
);
    p_reset_clear_r1: assert property (@(posedge clk)
        !rst_n |-> (flags == '0 && mode == '0 && count == '0));

    p_count_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (count != $past(count)) |-> (count == $past(count) + CW'(1)));

    p_count_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> $stable(count));

    p_mode_readback_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == 4'h1) |=> (mode == $past(bus_wdata[NCH-1:0])));

    p_owned_drive_r4: assert property (@(posedge clk) disable iff (!rst_n)
        ((mode & act) & ~pin_oe) == '0);

    p_released_pin_r5: assert property (@(posedge clk) disable iff (!rst_n)
        ((~(mode & act)) & ((pin_oe ^ dir) | (pin_out ^ port))) == '0);
endmodule

bind cct_timer cct_timer_chk #(.NCH(NCH), .CW(CW)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .en       (s_q.en),
    .count    (s_q.count),
    .mode     (s_q.mode),
    .act      (s_q.act),
    .dir      (s_q.dir),
    .port     (s_q.port),
    .pin_oe   (pin_oe),
    .pin_out  (pin_out),
    .flags    (evt_flags),
    .bus_wr   (bus_wr),
    .bus_addr (bus_addr),
    .bus_wdata(bus_wdata)
);

// File: tb/cct_timer_tb_top.sv
module cct_timer_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0;
    logic [3:0]  bus_addr = 4'h0;
    logic [15:0] bus_wdata = 16'h0;
    logic [15:0] bus_rdata;
    logic [7:0]  pin_in = 8'h0;
    logic [7:0]  pin_out, pin_oe, evt_flags;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 0;

    always #5 clk = ~clk;

    cct_timer dut_i (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pin_in(pin_in),
        .pin_out(pin_out), .pin_oe(pin_oe), .evt_flags(evt_flags)
    );

    // ---------------- behavioural reference model ----------------
    int        m_en, m_sel, m_pre;
    bit [7:0]  m_mode, m_act, m_flags, m_port, m_dir;
    bit [7:0]  m_s1, m_s2, m_prev, m_cout;
    bit [15:0] m_count;
    bit [15:0] m_ch [8];

    task automatic model_reset();
        m_en = 0; m_sel = 0; m_pre = 0;
        m_mode = 0; m_act = 0; m_flags = 0; m_port = 0; m_dir = 0;
        m_s1 = 0; m_s2 = 0; m_prev = 0; m_cout = 0; m_count = 0;
        for (int i = 0; i < 8; i++) m_ch[i] = 0;
    endtask

    always @(posedge clk) begin
        if (!rst_n) model_reset();
        else begin
            int period;
            bit tk;
            bit [15:0] cnx;
            bit [7:0] ev, clr;
            bit [15:0] nch [8];
            period = 1 << m_sel;
            tk  = (m_en != 0) && ((m_pre % period) == period - 1);
            cnx = m_count + (tk ? 16'd1 : 16'd0);
            ev = 0; clr = 0;
            for (int i = 0; i < 8; i++) begin
                bit capt, match;
                capt  = !m_mode[i] && m_s2[i] && !m_prev[i];
                match = m_mode[i] && tk && (m_ch[i] == cnx);
                nch[i] = m_ch[i];
                if (capt) nch[i] = m_count;
                else if (bus_wr && bus_addr == 4'(8 + i)) nch[i] = bus_wdata;
                if (match && m_act[i]) m_cout[i] = ~m_cout[i];
                ev[i] = capt | match;
            end
            for (int i = 0; i < 8; i++) m_ch[i] = nch[i];
            m_prev = m_s2; m_s2 = m_s1; m_s1 = pin_in;
            m_pre = (m_en != 0) ? (m_pre + 1) % 128 : 0;
            m_count = cnx;
            if (bus_wr) begin
                case (bus_addr)
                    4'h0: begin m_en = bus_wdata[0]; m_sel = bus_wdata[3:1]; end
                    4'h1: m_mode = bus_wdata[7:0];
                    4'h2: m_act  = bus_wdata[7:0];
                    4'h3: clr    = bus_wdata[7:0];
                    4'h5: m_port = bus_wdata[7:0];
                    4'h6: m_dir  = bus_wdata[7:0];
                    default: ;
                endcase
            end
            m_flags = (m_flags & ~clr) | ev;
        end
    end

    function automatic bit [15:0] model_rd(bit [3:0] a);
        case (a)
            4'h0: return 16'({m_sel[2:0], m_en[0]});
            4'h1: return 16'(m_mode);
            4'h2: return 16'(m_act);
            4'h3: return 16'(m_flags);
            4'h4: return m_count;
            4'h5: return 16'(m_port);
            4'h6: return 16'(m_dir);
            4'h7: return 16'h0;
            default: return m_ch[a[2:0]];
        endcase
    endfunction

    function automatic string rd_tag(bit [3:0] a);
        case (a)
            4'h1: return "R3";
            4'h3: return "R9";
            4'h4: return "R10";
            4'h5, 4'h6: return "R5";
            4'h0: return "R2";
            default: return "R7";
        endcase
    endfunction

    task automatic chk(string req, int actual, int expected);
        n_chk++;
        if (actual != expected) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, actual, expected);
        end
    endtask

    // Compare against the model on every clock, after the edge has settled
    always @(posedge clk) begin
        #1;
        if (rst_n && !done) begin
            bit [7:0] own;
            own = m_mode & m_act;
            chk("R4_pin_oe", pin_oe, own | m_dir);
            chk("R6_pin_out", pin_out, (own & m_cout) | (~own & m_port));
            chk("R9_flags", evt_flags, m_flags);
            chk(rd_tag(bus_addr), bus_rdata, model_rd(bus_addr));
        end
    end

    // ---------------- stimulus helpers ----------------
    task automatic wr_reg(bit [3:0] a, bit [15:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic set_rd(bit [3:0] a);
        @(negedge clk);
        bus_addr = a;
        @(negedge clk);
    endtask

    task automatic idle(int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic finish_run();
        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    initial begin
        #2_000_000;
        n_chk++; n_fail++;
        $display("FAIL watchdog actual=hung expected=done");
        finish_run();
    end

    initial begin
        idle(3);
        rst_n = 1'b1;
        // R1: reset state
        set_rd(4'h1);
        chk("R1_oe", pin_oe, 0);
        chk("R1_flags", evt_flags, 0);
        chk("R1_mode", bus_rdata, 0);
        set_rd(4'h4);
        chk("R1_count", bus_rdata, 0);

        // R5: general-purpose drive
        wr_reg(4'h6, 16'h000F);
        wr_reg(4'h5, 16'h00A5);
        idle(1);
        chk("R5_oe", pin_oe, 8'h0F);
        chk("R5_out", pin_out, 8'hA5);

        // R8/R4: compare channels 0 and 1, channel 0 owns its pin
        wr_reg(4'h8, 16'd20);
        wr_reg(4'h9, 16'd30);
        wr_reg(4'h2, 16'h0001);
        wr_reg(4'h1, 16'h0003);
        set_rd(4'h1);
        chk("R3_readback", bus_rdata, 16'h0003);
        wr_reg(4'h0, 16'h0001);
        idle(40);
        chk("R8_flags", evt_flags, 8'h03);
        chk("R8_toggle", pin_out[0], 1);

        // R4: direction bit ignored while owned
        wr_reg(4'h6, 16'h000E);
        idle(1);
        chk("R4_forced_oe", pin_oe[0], 1);
        wr_reg(4'h6, 16'h000F);

        // R6: port write latched while owned, driven after release
        wr_reg(4'h5, 16'h005A);
        idle(1);
        chk("R6_held", pin_out[0], 1);
        wr_reg(4'h2, 16'h0000);
        idle(1);
        chk("R6_released", pin_out[0], 0);
        chk("R6_oe", pin_oe[0], 1);

        // R9: write-one-to-clear
        wr_reg(4'h3, 16'h0001);
        idle(1);
        chk("R9_clear", evt_flags, 8'h02);

        // R9: clears every cycle across a compare match; event must win
        wr_reg(4'h3, 16'h0002);
        wr_reg(4'h9, m_count + 16'd12);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = 4'h3; bus_wdata = 16'h0002;
        idle(30);
        bus_wr = 1'b0;
        idle(2);

        // R7: capture on channel 4; channel 3 in compare mode ignores its pin
        wr_reg(4'h1, 16'h000B);
        wr_reg(4'h3, 16'h00FF);
        @(negedge clk);
        pin_in = 8'h18;
        idle(6);
        chk("R7_flag", evt_flags, 8'h10);
        set_rd(4'hC);
        chk("R7_value", bus_rdata, m_ch[4]);
        set_rd(4'hB);
        chk("R7_ignored", bus_rdata, 0);
        @(negedge clk);
        pin_in = 8'h00;
        idle(4);

        // R10: counter write ignored
        wr_reg(4'h4, 16'h1234);
        set_rd(4'h4);
        chk("R10_count", bus_rdata, m_count);

        // R2: divide by 8 over a 32-clock window
        wr_reg(4'h0, 16'h0007);
        begin
            int a, b;
            set_rd(4'h4);
            a = bus_rdata;
            idle(32);
            b = bus_rdata;
            chk("R2_div8", b - a, 4);
            // R2: disabled counter holds
            wr_reg(4'h0, 16'h0000);
            idle(1);
            a = bus_rdata;
            idle(10);
            chk("R2_hold", bus_rdata, a);
        end
        idle(2);
        finish_run();
    end
endmodule